// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block guards a pair of byte-wide I/O locations, an index port and a data port one address above it, that together give access to a small set of configuration registers. Out of reset the pair is locked. A host unlocks it by writing a four-byte key to the index port. Once unlocked, the host writes a register number to the index port and then reads or writes that register through the data port. Writing the exit command to the exit register locks the pair again.

The register set has a read-only chip identifier and version, a logical device selector, a flash control register and, for logical device 7, a two-byte base address for a serial flash engine and a flash chip select bit. The decoded fields of these registers drive the block's outputs. A strap input chooses which of two index addresses the block answers on. The last byte of the key depends on that choice.

Top module: `cfg_port_unlock`

## Requirements
- R1: After reset the port is locked (`unlocked_o`=0), the index is 0, `flash_base_o` equals the BASE_RESET parameter (16'h0820 by default), the control register equals CTL_RESET with bit 4 cleared (default 8'h1E gives 6'h0E, so `lpc_wr_en_o`=0), `chip_sel_o`=0 and the logical device is 0.
- R2: The index port is 16'h002E when `strap_alt_i`=0 and 16'h004E when it is 1, and the data port is the index port + 1. Index-port writes of 8'h87, 8'h01, 8'h55 and then a fourth byte unlock the port one cycle after that fourth write. The fourth byte is 8'h55 when `strap_alt_i`=0 and 8'hAA when it is 1. A wrong fourth byte does not unlock the port.
- R3: Any index-port write that does not match the next key byte restarts key detection. If that byte is 8'h87 it counts as the first key byte of a new attempt.
- R4: While the port is locked, reads at either port return 8'hFF and data-port writes change no register and no output.
- R5: While the port is unlocked, reading the index port returns the last index written. Registers 8'h20, 8'h21 and 8'h22 read the ID high byte, the ID low byte and the version byte (defaults 8'h87, 8'h16, 8'h01). Writes to these three registers are ignored.
- R6: Register 8'h07 is the logical device number. It is readable and writable. Registers 8'h64, 8'h65 and 8'hEF respond only while it holds 7. For any other device number they read 8'h00 and writes to them are ignored. Unlisted registers read 8'h00.
- R7: Register 8'h64 is the high byte and 8'h65 the low byte of `flash_base_o`. Only the high-byte bits [3:0] are stored, and the low-byte bits [2:0] always read 0, so the base is 8-aligned and below 16'h1000.
- R8: In register 8'h24, bit 0 drives `suspend_o`, bits [3:1] drive `seg_en_o`, bit 4 drives `lpc_wr_en_o` and bit 5 drives `pin_sel_o`. Bits [7:6] read 0.
- R9: In register 8'hEF, bit 0 drives `chip_sel_o` and reads back as written. Its other bits read 0.
- R10: Writing 8'h02 to register 8'h02 locks the port one cycle later and resets the index to 0. Writing any other value to register 8'h02 leaves the port unlocked.
- R11: Accesses at any address other than the selected index and data ports are ignored: reads return 8'hFF and writes have no effect, including key bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_alt_i | input | 1 | Chooses the alternate index address and key |
| io_wr_i | input | 1 | I/O write strobe, one cycle per byte |
| io_rd_i | input | 1 | I/O read strobe |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, combinational, 8'hFF when not driven |
| unlocked_o | output | 1 | Configuration mode active |
| flash_base_o | output | 16 | Flash engine base address |
| suspend_o | output | 1 | Control bit 0 |
| seg_en_o | output | 3 | Flash segment enables, control bits [3:1] |
| lpc_wr_en_o | output | 1 | Host write to flash enable, control bit 4 |
| pin_sel_o | output | 1 | Flash pin select, control bit 5 |
| chip_sel_o | output | 1 | Active flash chip select |

## Verification
The bench targets key sequences that break partway: a repeated 8'h87 in the middle of a key, and a key that ends with the other strap's fourth byte. A detector that simply resets to idle on a mismatch would miss the unlock after a break on 8'h87. A detector that ignores the strap would unlock on the wrong key. It checks that the base address is masked, that the device-7 registers are hidden under another device number, and that the exit register relocks only on the exact command. Errors here show up as an unaligned or out-of-range base, a stray chip select, or a port that cannot be closed. Random interleavings of key bytes, register numbers and data at the index, data and foreign addresses show whether locked-state writes or foreign-address writes ever leak into the stored registers.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_B0      = 8'h87;
  localparam logic [7:0] KEY_B1      = 8'h01;
  localparam logic [7:0] KEY_B2      = 8'h55;
  localparam logic [7:0] KEY_B3_PRI  = 8'h55;
  localparam logic [7:0] KEY_B3_ALT  = 8'hAA;

  localparam logic [7:0] REG_EXIT    = 8'h02;
  localparam logic [7:0] REG_DEV     = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_VER     = 8'h22;
  localparam logic [7:0] REG_CTL     = 8'h24;
  localparam logic [7:0] REG_BASE_HI = 8'h64;
  localparam logic [7:0] REG_BASE_LO = 8'h65;
  localparam logic [7:0] REG_CHIPSEL = 8'hEF;

  localparam logic [7:0] EXIT_CMD    = 8'h02;
  localparam logic [7:0] FLASH_DEV   = 8'h07;

  typedef struct packed {
    logic       pin_sel;
    logic       lpc_wr;
    logic [2:0] seg;
    logic       suspend;
  } flash_ctl_t;

  function automatic logic [7:0] key_byte(input logic [1:0] stage, input logic alt);
    case (stage)
      2'd0:    key_byte = KEY_B0;
      2'd1:    key_byte = KEY_B1;
      2'd2:    key_byte = KEY_B2;
      default: key_byte = alt ? KEY_B3_ALT : KEY_B3_PRI;
    endcase
  endfunction
endpackage

// File: rtl/cfg_key_det.sv
module cfg_key_det
  import cfg_port_pkg::*;
#(
  parameter int KEY_LEN = 4,
  localparam int STG_W  = $clog2(KEY_LEN)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       wr_i,
  input  logic       alt_i,
  input  logic [7:0] data_i,
  output logic       hit_o
);
  logic [STG_W-1:0] stage_q;
  logic             match;
  logic             last;

  assign match = data_i == key_byte(2'(stage_q), alt_i);
  assign last  = stage_q == STG_W'(KEY_LEN - 1);
  assign hit_o = en_i && wr_i && match && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (!en_i) begin
      stage_q <= '0;
    end else if (wr_i) begin
      if (match) stage_q <= last ? '0 : stage_q + 1'b1;
      // a break byte equal to the first key byte starts a new attempt
      else       stage_q <= (data_i == KEY_B0) ? STG_W'(1) : '0;
    end
  end
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID    = 16'h8716,
  parameter logic [7:0]  CHIP_VER   = 8'h01,
  parameter logic [15:0] BASE_RESET = 16'h0820,
  parameter logic [7:0]  CTL_RESET  = 8'h1E,
  parameter int          ALIGN_BITS = 3,
  parameter int          LIMIT_BITS = 12,
  localparam logic [7:0] HI_MASK    = 8'((1 << (LIMIT_BITS - 8)) - 1),
  localparam logic [7:0] LO_MASK    = ~8'((1 << ALIGN_BITS) - 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  index_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        exit_o,
  output logic [15:0] base_o,
  output flash_ctl_t  ctl_o,
  output logic        chip_sel_o
);
  logic [7:0]  dev_q;
  logic [7:0]  base_q [2];
  flash_ctl_t  ctl_q;
  logic        cs_q;
  logic        flash_dev;

  localparam logic [7:0] BASE_MASK [2] = '{LO_MASK, HI_MASK};
  localparam logic [7:0] BASE_IDX  [2] = '{REG_BASE_LO, REG_BASE_HI};

  assign flash_dev = dev_q == FLASH_DEV;
  assign exit_o    = wr_i && index_i == REG_EXIT && wdata_i == EXIT_CMD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q <= '0;
      ctl_q <= flash_ctl_t'(CTL_RESET[5:0] & 6'b10_1111);
      cs_q  <= 1'b0;
    end else if (wr_i) begin
      if (index_i == REG_DEV) dev_q <= wdata_i;
      if (index_i == REG_CTL) ctl_q <= flash_ctl_t'(wdata_i[5:0]);
      if (index_i == REG_CHIPSEL && flash_dev) cs_q <= wdata_i[0];
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) base_q[b] <= BASE_RESET[8*b +: 8] & BASE_MASK[b];
      else if (wr_i && flash_dev && index_i == BASE_IDX[b])
        base_q[b] <= wdata_i & BASE_MASK[b];
    end
  end

  always_comb begin
    case (index_i)
      REG_DEV:     rdata_o = dev_q;
      REG_ID_HI:   rdata_o = CHIP_ID[15:8];
      REG_ID_LO:   rdata_o = CHIP_ID[7:0];
      REG_VER:     rdata_o = CHIP_VER;
      REG_CTL:     rdata_o = {2'b00, ctl_q};
      REG_BASE_HI: rdata_o = flash_dev ? base_q[1] : 8'h00;
      REG_BASE_LO: rdata_o = flash_dev ? base_q[0] : 8'h00;
      REG_CHIPSEL: rdata_o = flash_dev ? {7'b0, cs_q} : 8'h00;
      default:     rdata_o = 8'h00;
    endcase
  end

  assign base_o     = {base_q[1], base_q[0]};
  assign ctl_o      = ctl_q;
  assign chip_sel_o = cs_q;
endmodule

// File: rtl/cfg_port_unlock.sv
module cfg_port_unlock
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] PRI_PORT   = 16'h002E,
  parameter logic [15:0] ALT_PORT   = 16'h004E,
  parameter logic [15:0] CHIP_ID    = 16'h8716,
  parameter logic [7:0]  CHIP_VER   = 8'h01,
  parameter logic [15:0] BASE_RESET = 16'h0820,
  parameter logic [7:0]  CTL_RESET  = 8'h1E
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        strap_alt_i,
  input  logic        io_wr_i,
  input  logic        io_rd_i,
  input  logic [15:0] io_addr_i,
  input  logic [7:0]  io_wdata_i,
  output logic [7:0]  io_rdata_o,
  output logic        unlocked_o,
  output logic [15:0] flash_base_o,
  output logic        suspend_o,
  output logic [2:0]  seg_en_o,
  output logic        lpc_wr_en_o,
  output logic        pin_sel_o,
  output logic        chip_sel_o
);
  logic [15:0] idx_port;
  logic        hit_idx, hit_dat;
  logic        unl_q;
  logic [7:0]  index_q;
  logic        key_hit, exit_cmd;
  logic [7:0]  cfg_rdata;
  flash_ctl_t  ctl;

  assign idx_port = strap_alt_i ? ALT_PORT : PRI_PORT;
  assign hit_idx  = io_addr_i == idx_port;
  assign hit_dat  = io_addr_i == idx_port + 16'd1;

  cfg_key_det #(.KEY_LEN(4)) i_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!unl_q),
    .wr_i   (io_wr_i && hit_idx),
    .alt_i  (strap_alt_i),
    .data_i (io_wdata_i),
    .hit_o  (key_hit)
  );

  cfg_reg_file #(
    .CHIP_ID    (CHIP_ID),
    .CHIP_VER   (CHIP_VER),
    .BASE_RESET (BASE_RESET),
    .CTL_RESET  (CTL_RESET)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (unl_q && io_wr_i && hit_dat),
    .index_i    (index_q),
    .wdata_i    (io_wdata_i),
    .rdata_o    (cfg_rdata),
    .exit_o     (exit_cmd),
    .base_o     (flash_base_o),
    .ctl_o      (ctl),
    .chip_sel_o (chip_sel_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unl_q   <= 1'b0;
      index_q <= '0;
    end else if (exit_cmd) begin
      unl_q   <= 1'b0;
      index_q <= '0;
    end else if (key_hit) begin
      unl_q   <= 1'b1;
    end else if (unl_q && io_wr_i && hit_idx) begin
      index_q <= io_wdata_i;
    end
  end

  always_comb begin
    io_rdata_o = 8'hFF;
    if (io_rd_i && unl_q) begin
      if (hit_idx)      io_rdata_o = index_q;
      else if (hit_dat) io_rdata_o = cfg_rdata;
    end
  end

  assign unlocked_o  = unl_q;
  assign suspend_o   = ctl.suspend;
  assign seg_en_o    = ctl.seg;
  assign lpc_wr_en_o = ctl.lpc_wr;
  assign pin_sel_o   = ctl.pin_sel;
endmodule

// File: rtl/cfg_port_unlock_chk.sv
module cfg_port_unlock_chk #(
  parameter logic [15:0] PRI_PORT = 16'h002E,
  parameter logic [15:0] ALT_PORT = 16'h004E
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        strap_alt_i,
  input logic        io_wr_i,
  input logic        io_rd_i,
  input logic [15:0] io_addr_i,
  input logic [7:0]  io_wdata_i,
  input logic [7:0]  io_rdata_o,
  input logic        unlocked_o,
  input logic [15:0] flash_base_o,
  input logic        suspend_o,
  input logic [2:0]  seg_en_o,
  input logic        lpc_wr_en_o,
  input logic        pin_sel_o,
  input logic        chip_sel_o
);
  logic [15:0] ip, dp;
  logic [5:0]  ctl_bits;
  assign ip = strap_alt_i ? ALT_PORT : PRI_PORT;
  assign dp = ip + 16'd1;
  assign ctl_bits = {pin_sel_o, lpc_wr_en_o, seg_en_o, suspend_o};

  a_r2_unlock_after_index_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(io_wr_i && io_addr_i == ip));

  a_r10_lock_after_exit_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(unlocked_o) |-> $past(io_wr_i && io_addr_i == dp && io_wdata_i == 8'h02));

  a_r4_locked_read_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && io_rd_i) |-> io_rdata_o == 8'hFF);

  a_r4_locked_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && io_wr_i) |=> ($stable(flash_base_o) && $stable(ctl_bits) && $stable(chip_sel_o)));

  a_r11_foreign_read_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i != ip && io_addr_i != dp) |-> io_rdata_o == 8'hFF);

  a_r11_foreign_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i != ip && io_addr_i != dp) |=> ($stable(unlocked_o) && $stable(flash_base_o)));

  a_r7_base_quiet_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_i |=> $stable(flash_base_o));
endmodule

bind cfg_port_unlock cfg_port_unlock_chk #(.PRI_PORT(PRI_PORT), .ALT_PORT(ALT_PORT)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .strap_alt_i  (strap_alt_i),
  .io_wr_i      (io_wr_i),
  .io_rd_i      (io_rd_i),
  .io_addr_i    (io_addr_i),
  .io_wdata_i   (io_wdata_i),
  .io_rdata_o   (io_rdata_o),
  .unlocked_o   (unlocked_o),
  .flash_base_o (flash_base_o),
  .suspend_o    (suspend_o),
  .seg_en_o     (seg_en_o),
  .lpc_wr_en_o  (lpc_wr_en_o),
  .pin_sel_o    (pin_sel_o),
  .chip_sel_o   (chip_sel_o)
);

// File: tb/test_cfg_port_unlock.sv
module test_cfg_port_unlock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        unlocked, suspend, lpc_wr_en, pin_sel, chip_sel;
  logic [15:0] flash_base;
  logic [2:0]  seg_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  bit        m_unl;
  int        m_stage;
  logic [7:0]  m_idx, m_dev, m_cs;
  logic [15:0] m_base;
  logic [5:0]  m_ctl;

  always #4 clk = ~clk;

  cfg_port_unlock i_cfg_port_unlock (
    .clk_i(clk), .rst_ni(rst_n), .strap_alt_i(strap),
    .io_wr_i(io_wr), .io_rd_i(io_rd), .io_addr_i(io_addr), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .unlocked_o(unlocked), .flash_base_o(flash_base),
    .suspend_o(suspend), .seg_en_o(seg_en), .lpc_wr_en_o(lpc_wr_en),
    .pin_sel_o(pin_sel), .chip_sel_o(chip_sel)
  );

  function automatic logic [15:0] iport();
    return strap ? 16'h004E : 16'h002E;
  endfunction

  function automatic logic [7:0] key_exp(int s);
    case (s)
      0: return 8'h87;
      1: return 8'h01;
      2: return 8'h55;
      default: return strap ? 8'hAA : 8'h55;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a);
    if (!m_unl) return 8'hFF;
    if (a == iport()) return m_idx;
    if (a != iport() + 16'd1) return 8'hFF;
    case (m_idx)
      8'h07: return m_dev;
      8'h20: return 8'h87;
      8'h21: return 8'h16;
      8'h22: return 8'h01;
      8'h24: return {2'b00, m_ctl};
      8'h64: return (m_dev == 8'h07) ? m_base[15:8] : 8'h00;
      8'h65: return (m_dev == 8'h07) ? m_base[7:0] : 8'h00;
      8'hEF: return (m_dev == 8'h07) ? m_cs : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_unl = 0; m_stage = 0; m_idx = 0; m_dev = 0; m_cs = 0;
    m_base = 16'h0820; m_ctl = 6'h0E;
  endtask

  task automatic model_wr(logic [15:0] a, logic [7:0] d);
    if (a == iport()) begin
      if (m_unl) m_idx = d;
      else if (d == key_exp(m_stage)) begin
        if (m_stage == 3) begin m_unl = 1; m_stage = 0; end
        else m_stage++;
      end else m_stage = (d == 8'h87) ? 1 : 0;
    end else if (a == iport() + 16'd1 && m_unl) begin
      case (m_idx)
        8'h02: if (d == 8'h02) begin m_unl = 0; m_idx = 0; end
        8'h07: m_dev = d;
        8'h24: m_ctl = d[5:0];
        8'h64: if (m_dev == 8'h07) m_base[15:8] = d & 8'h0F;
        8'h65: if (m_dev == 8'h07) m_base[7:0] = d & 8'hF8;
        8'hEF: if (m_dev == 8'h07) m_cs = {7'b0, d[0]};
        default: ;
      endcase
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(string tag);
    chk({tag, " unlocked"}, 32'(unlocked), 32'(m_unl));
    chk({tag, " base"}, 32'(flash_base), 32'(m_base));
    chk({tag, " ctl"}, 32'({pin_sel, lpc_wr_en, seg_en, suspend}), 32'(m_ctl));
    chk({tag, " chip_sel"}, 32'(chip_sel), 32'(m_cs[0]));
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(string tag, logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    chk(tag, 32'(io_rdata), 32'(exp_read(a)));
    io_rd = 1'b0;
  endtask

  task automatic rd_val(string tag, logic [15:0] a, logic [7:0] e);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    chk(tag, 32'(io_rdata), 32'(e));
    io_rd = 1'b0;
  endtask

  task automatic key(logic [7:0] last);
    wr(iport(), 8'h87); wr(iport(), 8'h01); wr(iport(), 8'h55); wr(iport(), last);
  endtask

  task automatic reg_wr(logic [7:0] r, logic [7:0] d);
    wr(iport(), r); wr(iport() + 16'd1, d);
  endtask

  task automatic reg_rd(string tag, logic [7:0] r, logic [7:0] e);
    wr(iport(), r); rd_val(tag, iport() + 16'd1, e);
  endtask

  task automatic do_reset(bit s);
    @(negedge clk);
    rst_n = 1'b0; strap = s;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] picks [14];
    picks = '{8'h87, 8'h01, 8'h55, 8'hAA, 8'h02, 8'h07, 8'h20, 8'h21,
              8'h22, 8'h24, 8'h64, 8'h65, 8'hEF, 8'h3C};
    void'($urandom(32'd1234));
    model_reset();
    do_reset(1'b0);

    // R1 reset state
    @(negedge clk); #1;
    chk_outs("R1 reset");
    chk("R1 lpc_wr cleared", 32'(lpc_wr_en), 32'd0);

    // R4 locked: reads FF, data write inert
    rd_val("R4 locked index read", 16'h002E, 8'hFF);
    rd_val("R4 locked data read", 16'h002F, 8'hFF);
    wr(16'h002F, 8'h55);
    @(negedge clk); #1; chk_outs("R4 locked data write");

    // R11 key at foreign address
    wr(16'h004E, 8'h87); wr(16'h004E, 8'h01); wr(16'h004E, 8'h55); wr(16'h004E, 8'h55);
    @(negedge clk); #1; chk("R11 foreign key no unlock", 32'(unlocked), 32'd0);

    // R2 wrong fourth byte, then correct key
    key(8'hAA);
    @(negedge clk); #1; chk("R2 wrong fourth byte", 32'(unlocked), 32'd0);
    key(8'h55);
    @(negedge clk); #1; chk("R2 primary key unlocks", 32'(unlocked), 32'd1);

    // R5 id and version, index readback
    wr(16'h002E, 8'h21); rd_val("R5 index readback", 16'h002E, 8'h21);
    reg_rd("R5 id high", 8'h20, 8'h87);
    reg_rd("R5 id low", 8'h21, 8'h16);
    reg_rd("R5 version", 8'h22, 8'h01);
    reg_wr(8'h20, 8'h00);
    reg_rd("R5 id write ignored", 8'h20, 8'h87);

    // R6 device gating
    reg_wr(8'h07, 8'h03);
    reg_rd("R6 device readback", 8'h07, 8'h03);
    reg_wr(8'h64, 8'h0A);
    reg_rd("R6 base hidden", 8'h64, 8'h00);
    reg_wr(8'hEF, 8'h01);
    @(negedge clk); #1; chk_outs("R6 gated writes");
    reg_rd("R6 unlisted reg", 8'h30, 8'h00);
    reg_wr(8'h07, 8'h07);
    reg_rd("R6 base visible", 8'h64, 8'h08);

    // R7 base masking
    reg_wr(8'h64, 8'hFF);
    reg_wr(8'h65, 8'hFF);
    reg_rd("R7 high masked", 8'h64, 8'h0F);
    reg_rd("R7 low aligned", 8'h65, 8'hF8);
    @(negedge clk); #1; chk("R7 base output", 32'(flash_base), 32'h0FF8);

    // R8 control fields
    reg_wr(8'h24, 8'hFF);
    reg_rd("R8 ctl upper bits zero", 8'h24, 8'h3F);
    @(negedge clk); #1; chk_outs("R8 ctl all set");
    reg_wr(8'h24, 8'h12);
    @(negedge clk); #1;
    chk("R8 suspend", 32'(suspend), 32'd0);
    chk("R8 seg", 32'(seg_en), 32'd1);
    chk("R8 lpc write", 32'(lpc_wr_en), 32'd1);
    chk("R8 pin sel", 32'(pin_sel), 32'd0);

    // R9 chip select
    reg_wr(8'hEF, 8'hFF);
    reg_rd("R9 chip sel readback", 8'hEF, 8'h01);
    @(negedge clk); #1; chk("R9 chip_sel out", 32'(chip_sel), 32'd1);
    reg_wr(8'hEF, 8'hFE);
    @(negedge clk); #1; chk("R9 chip_sel clear", 32'(chip_sel), 32'd0);

    // R11 foreign reads/writes while unlocked
    rd_val("R11 foreign read", 16'h0030, 8'hFF);
    wr(16'h0030, 8'h02);
    @(negedge clk); #1; chk_outs("R11 foreign write");

    // R10 exit
    reg_wr(8'h02, 8'h03);
    @(negedge clk); #1; chk("R10 other value keeps unlock", 32'(unlocked), 32'd1);
    reg_wr(8'h02, 8'h02);
    @(negedge clk); #1; chk("R10 exit locks", 32'(unlocked), 32'd0);
    rd_val("R10 locked read", 16'h002F, 8'hFF);

    // R3 break on 0x87 restarts as first byte
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); key(8'h55);
    @(negedge clk); #1; chk("R3 break on 87 then key", 32'(unlocked), 32'd1);
    rd_val("R10 index reset on lock", 16'h002E, 8'h00);
    reg_wr(8'h02, 8'h02);
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'h87);
    wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
    @(negedge clk); #1; chk("R3 late break on 87", 32'(unlocked), 32'd1);
    reg_wr(8'h02, 8'h02);
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h13); wr(16'h002E, 8'h01);
    wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
    @(negedge clk); #1; chk("R3 break restarts", 32'(unlocked), 32'd0);

    // R2 alternate strap
    do_reset(1'b1);
    key(8'h55);
    @(negedge clk); #1; chk("R2 alt rejects primary key", 32'(unlocked), 32'd0);
    key(8'hAA);
    @(negedge clk); #1; chk("R2 alt key unlocks", 32'(unlocked), 32'd1);
    rd_val("R2 primary port ignored under alt", 16'h002F, 8'hFF);
    reg_rd("R5 id via alt port", 8'h21, 8'h16);

    // random mix, both straps
    for (int pass = 0; pass < 2; pass++) begin
      do_reset(pass[0]);
      for (int i = 0; i < 1500; i++) begin
        int op;
        logic [15:0] a;
        logic [7:0] d;
        op = int'($urandom_range(0, 9));
        case ($urandom_range(0, 5))
          0, 1, 2: a = iport();
          3, 4:    a = iport() + 16'd1;
          default: a = (pass == 0) ? 16'h004E : 16'h002F;
        endcase
        d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : picks[$urandom_range(0, 13)];
        if (op < 6) wr(a, d);
        else rd("R4 R5 R6 R11 random read", a);
        if (i % 8 == 0) begin @(negedge clk); #1; chk_outs("R7 R8 R9 R10 random outputs"); end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule